// File: doc/BRIEF.md
# Write-Through Data Cache with Store Queue

This block sits between a processor's load/store port and a slower backing memory. It keeps a direct-mapped array of one-word lines, each guarded by a valid bit and a stored tag. Loads that find their word return it one cycle after acceptance. Loads that do not find it stall the processor while the line is fetched from memory.

Every store is copied into a four-entry first-in first-out queue of address/data pairs. The queue writes memory in the background. A store that finds its line also updates the cached word. The processor therefore waits on a store only when the queue is full.

A single memory port is shared between queue drains and line fills. A fill is never issued while any store is still queued. Memory therefore always holds the latest value before it is read back into the cache.

Top module: `thru_cache`

## Requirements
- R1: A byte address selects line index from bits 11..2 and tag from bits 31..12. Bits 1..0 select nothing, so any byte of a cached word hits that word.
- R2: A load hits only when the indexed line is valid and its tag equals the address tag. A load to the same index with another tag misses and replaces the line.
- R3: A store that hits writes its data into the cached word. A following load of that word hits and returns the new data.
- R4: Every accepted store reaches memory. Stores are written in acceptance order, so the last store to a word is the value memory keeps.
- R5: A load hit raises `cpuReady` in the cycle the request is presented. `cpuRvalid` is high with the data in the following cycle.
- R6: On a load miss, `cpuReady` stays low until the line has been filled from memory. The load then completes with the memory word.
- R7: The store queue holds 4 entries. With memory stalled, four stores are accepted back to back without a stall, and a fifth waits until an entry drains.
- R8: A store that misses does not allocate a line, so a later load of that word misses.
- R9: A line fill is issued only when the store queue is empty. A load that misses on a word with a queued store therefore returns the stored value.
- R10: Reset clears every valid bit and discards queued stores. After reset, `cpuRvalid` and `memReq` are low and earlier lines miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request, held until accepted |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | 32 | Processor byte address |
| cpuWdata | input | 32 | Store data |
| cpuReady | output | 1 | Request accepted at this clock edge |
| cpuRdata | output | 32 | Load data |
| cpuRvalid | output | 1 | `cpuRdata` valid, one cycle after load acceptance |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | 1 = queue drain write, 0 = line fill read |
| memAddr | output | 32 | Memory byte address (bits 1..0 ignored by memory) |
| memWdata | output | 32 | Drain write data |
| memReady | input | 1 | Memory completes the request at this edge |
| memRdata | input | 32 | Fill data, valid while `memReady` is high |

## Verification
For a load hit, `cpuReady` is due combinationally in the cycle the request is presented, and `cpuRvalid` with data is due one edge later. The bench samples one time unit after each falling edge. It counts the cycles in which ready was low, so a hit must show zero stall cycles and a miss at least one.

A queued store reaches memory at the first edge where `memReady` is high. The bench therefore holds `memReady` low to keep entries in the queue while it probes stalls and fill ordering. It compares memory contents only after several free-running cycles have drained the queue.

// File: rtl/thru_cache_pkg.sv
package thru_cache_pkg;

  // Strobes from the control FSM into the datapath.
  typedef struct packed {
    logic accept;      // processor request taken at this edge
    logic push;        // enqueue store into write queue
    logic storeHitWr;  // update cached word with store data
    logic rdLatch;     // capture load data for next-cycle response
    logic memRead;     // issue line-fill read on memory port
    logic fillWr;      // write fill data, tag and valid into the line
  } ctrlStrobes_t;

endpackage

// File: rtl/thru_cache_ctrl.sv
module thru_cache_ctrl
  import thru_cache_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cpuReq,
  input  logic         cpuWe,
  input  logic         hit,
  input  logic         bufFull,
  input  logic         bufEmpty,
  input  logic         memReady,
  output ctrlStrobes_t st
);

  typedef enum logic [1:0] {S_IDLE, S_DRAIN, S_FILL} state_t;

  state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    st        = '0;
    nextState = state;
    unique case (state)
      S_IDLE: begin
        if (cpuReq) begin
          if (cpuWe) begin
            if (!bufFull) begin
              st.accept     = 1'b1;
              st.push       = 1'b1;
              st.storeHitWr = hit;
            end
          end else if (hit) begin
            st.accept  = 1'b1;
            st.rdLatch = 1'b1;
          end else begin
            nextState = S_DRAIN;
          end
        end
      end
      S_DRAIN: begin
        // queued stores must reach memory before the line is read back
        if (bufEmpty) nextState = S_FILL;
      end
      S_FILL: begin
        st.memRead = 1'b1;
        if (memReady) begin
          st.fillWr = 1'b1;
          nextState = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  // R9: a fill is only ever requested once the queue has emptied
  p_fill_after_drain_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DRAIN && !bufEmpty) |=> (state != S_FILL));

endmodule

// File: rtl/thru_cache_dp.sv
module thru_cache_dp
  import thru_cache_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 10,
  parameter int BUF_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      st,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              hit,
  output logic              bufFull,
  output logic              bufEmpty,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuRvalid,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdata
);

  localparam int LINES = 1 << IDX_W;
  localparam int OFF_W = 2;
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int PTR_W = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(BUF_DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BUF_DEPTH);

  // ---------------- line arrays ----------------
  logic [LINES-1:0]  validBits;
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [DATA_W-1:0] dataArr [LINES];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tagIn;

  assign idx   = cpuAddr[IDX_W+OFF_W-1:OFF_W];
  assign tagIn = cpuAddr[ADDR_W-1:IDX_W+OFF_W];
  assign hit   = validBits[idx] && (tagArr[idx] == tagIn);

  always_ff @(posedge clk) begin
    if (!rstN)          validBits      <= '0;
    else if (st.fillWr) validBits[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (st.fillWr) begin
      tagArr[idx]  <= tagIn;
      dataArr[idx] <= memRdata;
    end else if (st.storeHitWr) begin
      dataArr[idx] <= cpuWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuRvalid <= 1'b0;
      cpuRdata  <= '0;
    end else begin
      cpuRvalid <= st.rdLatch;
      if (st.rdLatch) cpuRdata <= dataArr[idx];
    end
  end

  // ---------------- store queue ----------------
  logic [ADDR_W-1:0] qAddr [BUF_DEPTH];
  logic [DATA_W-1:0] qData [BUF_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              pop;

  assign bufEmpty = (count == '0);
  assign bufFull  = (count == FULL_CNT);

  for (genvar g = 0; g < BUF_DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (st.push && wrPtr == PTR_W'(g)) begin
        qAddr[g] <= cpuAddr;
        qData[g] <= cpuWdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (st.push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (pop)     rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({st.push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // ---------------- memory port arbitration ----------------
  // Fill has the port only in the fill state, where the queue is empty.
  assign memReq   = st.memRead || !bufEmpty;
  assign memWe    = !st.memRead;
  assign memAddr  = st.memRead ? cpuAddr : qAddr[rdPtr];
  assign memWdata = qData[rdPtr];
  assign pop      = memReq && memWe && memReady;

  // ---------------- assertions ----------------
  p_push_not_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.push |-> !bufFull);

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  p_refill_queue_empty_r9: assert property (@(posedge clk) disable iff (!rstN)
    st.memRead |-> bufEmpty);

  p_fill_sets_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.fillWr |=> validBits[$past(idx)]);

  p_reset_empty_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (bufEmpty && !cpuRvalid));

endmodule

// File: rtl/thru_cache.sv
module thru_cache
  import thru_cache_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 10,
  parameter int BUF_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuRvalid,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdata
);

  ctrlStrobes_t st;
  logic hit, bufFull, bufEmpty;

  thru_cache_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .hit(hit), .bufFull(bufFull), .bufEmpty(bufEmpty),
    .memReady(memReady), .st(st)
  );

  thru_cache_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .BUF_DEPTH(BUF_DEPTH)
  ) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .hit(hit), .bufFull(bufFull), .bufEmpty(bufEmpty),
    .cpuRdata(cpuRdata), .cpuRvalid(cpuRvalid),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memReady(memReady), .memRdata(memRdata)
  );

  assign cpuReady = st.accept;

  // R5: an accepted load always answers on the next cycle
  p_load_resp_next_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && !cpuWe && cpuReady) |=> cpuRvalid);

  // R6: a load that misses is not taken in that cycle
  p_miss_no_accept_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && !cpuWe && !hit) |-> !cpuReady);

endmodule

// File: tb/test_thru_cache.sv
module test_thru_cache;

  localparam int MEM_WORDS = 2048;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0;
  logic        cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic        cpuReady, cpuRvalid, memReq, memWe;
  logic [31:0] cpuRdata, memAddr, memWdata, memRdata;
  logic        memHold = 1'b0;
  logic        memReady;

  logic [31:0] backing [MEM_WORDS];
  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  assign memReady = !memHold;
  assign memRdata = backing[memAddr[12:2]];

  thru_cache i_thru_cache (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuReady(cpuReady),
    .cpuRdata(cpuRdata), .cpuRvalid(cpuRvalid), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memReady(memReady), .memRdata(memRdata)
  );

  // backing memory model: writes land at the edge where the drain completes
  always @(posedge clk) begin
    if (memReq && memReady && memWe) backing[memAddr[12:2]] <= memWdata;
  end

  function automatic logic [31:0] initVal(input int w);
    return 32'h9000_0000 | (w * 13);
  endfunction

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      finishRun();
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doStore(input logic [31:0] a, input logic [31:0] d, input int relAfter, output int stalls);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = 1'b1; cpuAddr = a; cpuWdata = d; stalls = 0;
    forever begin
      #1;
      if (cpuReady) break;
      stalls++;
      if (stalls == relAfter) memHold = 1'b0;
      @(negedge clk);
    end
    @(negedge clk);
    cpuReq = 1'b0; cpuWe = 1'b0;
  endtask

  task automatic doLoad(input logic [31:0] a, input int relAfter, output logic [31:0] d, output int stalls, output logic rv);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = 1'b0; cpuAddr = a; stalls = 0;
    forever begin
      #1;
      if (cpuReady) break;
      stalls++;
      if (stalls == relAfter) memHold = 1'b0;
      @(negedge clk);
    end
    @(negedge clk);
    #1;
    rv = cpuRvalid; d = cpuRdata;
    cpuReq = 1'b0;
  endtask

  task automatic waitDrain();
    memHold = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  localparam logic [31:0] ADDR_A = 32'h0000_0040;  // index 16, tag 0
  localparam logic [31:0] ADDR_B = 32'h0000_1040;  // index 16, tag 1
  localparam logic [31:0] ADDR_C = 32'h0000_0180;
  localparam logic [31:0] ADDR_E = 32'h0000_0300;

  task automatic testResetState();
    #1;
    check(!cpuRvalid, "R10 rvalid after reset", 32'(cpuRvalid), 0);
    check(!memReq, "R10 memReq after reset", 32'(memReq), 0);
  endtask

  task automatic testMissFill();
    logic [31:0] d; int s; logic rv;
    doLoad(ADDR_A, -1, d, s, rv);
    check(s > 0, "R6 miss stalls", 32'(s), 1);
    check(rv && d == initVal(16), "R6 fill data", d, initVal(16));
  endtask

  task automatic testHit();
    logic [31:0] d; int s; logic rv;
    doLoad(ADDR_A, -1, d, s, rv);
    check(s == 0, "R5 hit no stall", 32'(s), 0);
    check(rv, "R5 rvalid next cycle", 32'(rv), 1);
    check(d == initVal(16), "R5 hit data", d, initVal(16));
    doLoad(ADDR_A + 32'd3, -1, d, s, rv);
    check(s == 0 && d == initVal(16), "R1 byte offset ignored", d, initVal(16));
  endtask

  task automatic testAlias();
    logic [31:0] d; int s; logic rv;
    doLoad(ADDR_B, -1, d, s, rv);
    check(s > 0, "R2 tag mismatch misses", 32'(s), 1);
    check(d == initVal(1040), "R2 alias data", d, initVal(1040));
    doLoad(ADDR_A, -1, d, s, rv);
    check(s > 0, "R2 replaced line misses", 32'(s), 1);
  endtask

  task automatic testStoreHit();
    logic [31:0] d; int s; logic rv;
    doStore(ADDR_A, 32'hCAFE_0001, -1, s);
    check(s == 0, "R3 store no stall", 32'(s), 0);
    doLoad(ADDR_A, -1, d, s, rv);
    check(s == 0 && d == 32'hCAFE_0001, "R3 store hit updates line", d, 32'hCAFE_0001);
    waitDrain();
    check(backing[16] == 32'hCAFE_0001, "R4 store reaches memory", backing[16], 32'hCAFE_0001);
  endtask

  task automatic testStoreMiss();
    logic [31:0] d; int s; logic rv;
    memHold = 1'b1;
    doStore(ADDR_C, 32'h5A5A_1234, -1, s);
    doLoad(ADDR_C, 3, d, s, rv);
    check(s > 0, "R8 store miss not allocated", 32'(s), 1);
    check(d == 32'h5A5A_1234, "R9 fill sees queued store", d, 32'h5A5A_1234);
    waitDrain();
  endtask

  task automatic testBurst();
    int s;
    memHold = 1'b1;
    doStore(32'h200, 32'h1111_0000, -1, s);
    check(s == 0, "R7 store 1 absorbed", 32'(s), 0);
    doStore(32'h204, 32'h2222_0000, -1, s);
    check(s == 0, "R7 store 2 absorbed", 32'(s), 0);
    doStore(32'h200, 32'h3333_0000, -1, s);
    check(s == 0, "R7 store 3 absorbed", 32'(s), 0);
    doStore(32'h208, 32'h4444_0000, -1, s);
    check(s == 0, "R7 store 4 absorbed", 32'(s), 0);
    doStore(32'h20C, 32'h5555_0000, 2, s);
    check(s > 0, "R7 fifth store stalls", 32'(s), 1);
    waitDrain();
    check(backing[128] == 32'h3333_0000, "R4 order last store wins", backing[128], 32'h3333_0000);
    check(backing[129] == 32'h2222_0000, "R4 second word", backing[129], 32'h2222_0000);
    check(backing[131] == 32'h5555_0000, "R4 fifth word", backing[131], 32'h5555_0000);
  endtask

  task automatic testReset();
    logic [31:0] d; int s; logic rv;
    doLoad(ADDR_A, -1, d, s, rv);
    memHold = 1'b1;
    doStore(ADDR_E, 32'hDEAD_BEEF, -1, s);
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1; memHold = 1'b0;
    #1;
    check(!memReq && !cpuRvalid, "R10 outputs idle after reset", {30'd0, memReq, cpuRvalid}, 0);
    repeat (10) @(negedge clk);
    check(backing[192] == initVal(192), "R10 queued store discarded", backing[192], initVal(192));
    doLoad(ADDR_A, -1, d, s, rv);
    check(s > 0, "R10 valid bits cleared", 32'(s), 1);
  endtask

  initial begin
    for (int w = 0; w < MEM_WORDS; w++) backing[w] = initVal(w);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testResetState();
    testMissFill();
    testHit();
    testAlias();
    testStoreHit();
    testStoreMiss();
    testBurst();
    testReset();
    finishRun();
  end

endmodule